// File: doc/BRIEF.md
# RTC interrupt mode generator

This block produces the active-low interrupt line of a real-time clock. The clock core supplies a 15-bit subsecond prescaler, which advances at 32768 Hz. It also supplies the current BCD hour, minute and second, and single-cycle strobes for each new second and each new minute. The generator looks at three mode bits in the configuration byte and at the 16-bit alarm word. From these it selects one of five behaviours: always idle, alarm on an hour/minute match, a frequency output taken from the prescaler, a short pulse at each minute that a configuration read can acknowledge, and a pulse at each minute that is held until the half-minute.

The output is registered. A change in any input appears on `irq_n` one clock after the edge that samples it. The calendar counting and the serial command path that loads the configuration and alarm registers are outside this block.

Top module: `rtc_irq_gen`

## Requirements
- R1: While `rst_n` is low, `irq_n` is high.
- R2: The mode comes only from `cfg[5]` (alarm enable), `cfg[3]` and `cfg[1]`. With all three at 0, `irq_n` stays high whatever the other inputs do, and the other `cfg` bits have no effect.
- R3: Alarm mode is `cfg[5,3,1]` = 1,0,0. In this mode `irq_n` is low while the clock's hour equals `alarm[7:0]` and its minute equals `alarm[15:8]`. The hour comparison covers bit 7 (PM flag) and bits 5:0. The minute comparison covers bits 6:0. The output stays low for every second of the matching minute.
- R4: The alarm hour is compared as raw bits, with no conversion between 12-hour and 24-hour codes. Hour 0x23 does not match an alarm hour of 0x91.
- R5: Frequency mode is `cfg[3]`=0 and `cfg[1]`=1, with `cfg[5]` ignored. In this mode `irq_n` equals the NOR of the 15 bits of (inverted prescaler AND `alarm[14:0]`).
- R6: In frequency mode, `alarm[0]` gates the fastest prescaler bit and `alarm[14]` gates the slowest. `alarm[15]` takes no part in the result.
- R7: Edge mode is `cfg[3]`=1 and `cfg[1]`=0. In this mode a `tick_min` pulse drives `irq_n` low on the next clock. A set takes priority over any release in the same cycle.
- R8: In edge mode, a `cfg_rd` pulse is ignored until 328 prescaler changes have been seen since `tick_min`. After that, a `cfg_rd` pulse releases `irq_n`.
- R9: In edge mode, a pending interrupt that has not been read is released by the next `tick_sec` that does not coincide with `tick_min`.
- R10: Steady mode is `cfg[3]`=1 and `cfg[1]`=1. In this mode the interrupt set by `tick_min` is held through `cfg_rd` and `tick_sec`. It is released when `second` equals BCD 0x30.
- R11: Selecting any mode other than edge or steady drops a pending per-minute interrupt. Returning to a per-minute mode does not restore it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| presc | input | 15 | Subsecond prescaler, bit 0 fastest |
| tick_sec | input | 1 | One-cycle strobe at each new second |
| tick_min | input | 1 | One-cycle strobe at each new minute |
| hour | input | 8 | BCD hour, bit 7 = PM |
| minute | input | 8 | BCD minute |
| second | input | 8 | BCD second |
| cfg | input | 8 | Configuration byte (mode bits 5, 3, 1) |
| alarm | input | 16 | Alarm word: hour/minute match or frequency mask |
| cfg_rd | input | 1 | One-cycle strobe on a configuration read |
| irq_n | output | 1 | Registered active-low interrupt |

## Verification
The assertions assume that `tick_min`, `tick_sec` and `cfg_rd` are single-cycle strobes. They also assume that `second` is a valid BCD value and that the prescaler moves by one step per change, so that counting changes measures time. The bench holds each strobe for exactly one clock and clears it before the next vector. It advances the prescaler one count at a time and sets `second` directly to BCD values, so every input stays within these assumptions.

// File: rtl/rtc_irq_gen.sv
module rtc_irq_gen #(
  parameter int PW        = 15,
  parameter int WIN_TICKS = 328
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] presc,
  input  logic          tick_sec,
  input  logic          tick_min,
  input  logic [7:0]    hour,
  input  logic [7:0]    minute,
  input  logic [7:0]    second,
  input  logic [7:0]    cfg,
  input  logic [15:0]   alarm,
  input  logic          cfg_rd,
  output logic          irq_n
);

  localparam int CW = $clog2(WIN_TICKS + 1);

  typedef enum logic [2:0] {M_OFF, M_ALARM, M_FREQ, M_EDGE, M_STEADY} mode_t;

  mode_t          mode;
  logic [PW-1:0]  presc_q;
  logic [CW-1:0]  win_cnt;
  logic           min_flag, min_flag_d, irq_d;

  always_comb begin
    case ({cfg[3], cfg[1]})
      2'b01:   mode = M_FREQ;
      2'b10:   mode = M_EDGE;
      2'b11:   mode = M_STEADY;
      default: mode = cfg[5] ? M_ALARM : M_OFF;
    endcase
  end

  wire alarm_hit = ((hour & 8'hBF) == (alarm[7:0] & 8'hBF)) &&
                   ((minute & 8'h7F) == (alarm[15:8] & 8'h7F));
  wire freq_lvl  = ~|(~presc & alarm[PW-1:0]);
  wire in_window = win_cnt < CW'(WIN_TICKS);
  wire per_min   = (mode == M_EDGE) || (mode == M_STEADY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
      win_cnt <= CW'(WIN_TICKS);
    end else begin
      presc_q <= presc;
      if (tick_min)
        win_cnt <= '0;
      else if (presc != presc_q && in_window)
        win_cnt <= win_cnt + 1'b1;
    end
  end

  always_comb begin
    min_flag_d = min_flag;
    if (!per_min)
      min_flag_d = 1'b0;
    else if (tick_min)
      min_flag_d = 1'b1;
    else if (mode == M_EDGE && (tick_sec || (cfg_rd && !in_window)))
      min_flag_d = 1'b0;
    else if (mode == M_STEADY && second == 8'h30)
      min_flag_d = 1'b0;
  end

  always_comb begin
    case (mode)
      M_ALARM: irq_d = alarm_hit;
      M_FREQ:  irq_d = ~freq_lvl;
      M_EDGE,
      M_STEADY: irq_d = min_flag_d;
      default: irq_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      min_flag <= 1'b0;
      irq_n    <= 1'b1;
    end else begin
      min_flag <= min_flag_d;
      irq_n    <= ~irq_d;
    end
  end

  // R2
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[5] == 1'b0 && cfg[3] == 1'b0 && cfg[1] == 1'b0) |=> irq_n);

  // R3
  alarm_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_ALARM && alarm_hit) |=> !irq_n);

  // R7
  minute_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == M_EDGE || mode == M_STEADY) && tick_min) |=> !irq_n);

  // R8
  early_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_EDGE && min_flag && cfg_rd && in_window && !tick_sec) |=> !irq_n);

  // R10
  half_minute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_STEADY && second == 8'h30 && !tick_min) |=> irq_n);

  // R11
  drop_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!per_min) |=> !min_flag);

endmodule

// File: tb/sim_rtc_irq_gen.sv
module sim_rtc_irq_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] presc = '0;
  logic        tick_sec = 1'b0;
  logic        tick_min = 1'b0;
  logic [7:0]  hour = 8'h10;
  logic [7:0]  minute = 8'h20;
  logic [7:0]  second = 8'h05;
  logic [7:0]  cfg = 8'h00;
  logic [15:0] alarm = 16'h0000;
  logic        cfg_rd = 1'b0;
  logic        irq_n;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;
  bit   exp_q[$];
  string tag_q[$];
  bit   m_exp;
  string m_tag;

  always #10 clk = ~clk;

  rtc_irq_gen u0 (
    .clk(clk), .rst_n(rst_n), .presc(presc), .tick_sec(tick_sec),
    .tick_min(tick_min), .hour(hour), .minute(minute), .second(second),
    .cfg(cfg), .alarm(alarm), .cfg_rd(cfg_rd), .irq_n(irq_n)
  );

  task automatic step(input bit e, input string tag);
    @(posedge clk);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    tick_sec = 1'b0;
    tick_min = 1'b0;
    cfg_rd   = 1'b0;
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      m_exp = exp_q.pop_front();
      m_tag = tag_q.pop_front();
      n_vec++;
      if (irq_n !== m_exp) begin
        n_bad++;
        $display("FAIL %s: irq_n=%b expected %b", m_tag, irq_n, m_exp);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_vec++;
    if (irq_n !== 1'b1) begin
      n_bad++;
      $display("FAIL R1: irq_n=%b expected 1", irq_n);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R2 disabled, non-mode bits set
    cfg = 8'hC5; presc = 15'h0000; alarm = 16'hFFFF;
    step(1'b1, "R2 other cfg bits");
    tick_min = 1'b1; step(1'b1, "R2 tick_min ignored");

    // R3 / R4 alarm
    cfg = 8'h20; alarm = 16'h4591; hour = 8'h91; minute = 8'h45; second = 8'h00;
    step(1'b0, "R3 match");
    second = 8'h59; step(1'b0, "R3 whole minute");
    hour = 8'h11; step(1'b1, "R3 AM vs PM");
    hour = 8'h91; minute = 8'h46; step(1'b1, "R3 minute differs");
    hour = 8'h23; minute = 8'h45; step(1'b1, "R4 no 24h conversion");
    alarm = 16'h4523; step(1'b0, "R4 raw 24h match");

    // R5 / R6 frequency
    cfg = 8'h02; alarm = 16'h0001; presc = 15'h0000;
    step(1'b0, "R5 bit0 low");
    presc = 15'h0001; step(1'b1, "R5 bit0 high");
    cfg = 8'h22; presc = 15'h0000; step(1'b0, "R5 A bit ignored");
    alarm = 16'h8000; step(1'b1, "R6 bit15 excluded");
    alarm = 16'h4000; step(1'b0, "R6 bit14 low");
    presc = 15'h4000; step(1'b1, "R6 bit14 high");
    alarm = 16'h0000; presc = 15'h0000; step(1'b1, "R5 empty mask");

    // R7 / R8 / R9 edge mode
    cfg = 8'h08; step(1'b1, "R7 idle");
    tick_min = 1'b1; step(1'b0, "R7 set");
    cfg_rd = 1'b1; step(1'b0, "R8 read at start ignored");
    for (int i = 0; i < 327; i++) begin
      presc = presc + 15'd1;
      step(1'b0, "R8 inside window");
    end
    cfg_rd = 1'b1; step(1'b0, "R8 read at 327 ignored");
    presc = presc + 15'd1; step(1'b0, "R8 328th change");
    cfg_rd = 1'b1; step(1'b1, "R8 read after window");
    tick_min = 1'b1; tick_sec = 1'b1; step(1'b0, "R7 set wins");
    step(1'b0, "R9 held");
    tick_sec = 1'b1; step(1'b1, "R9 released by tick_sec");

    // R10 / R11 steady mode
    cfg = 8'h0A; second = 8'h00; step(1'b1, "R10 idle");
    tick_min = 1'b1; step(1'b0, "R10 set");
    for (int i = 0; i < 330; i++) begin
      presc = presc + 15'd1;
      step(1'b0, "R10 held");
    end
    cfg_rd = 1'b1; step(1'b0, "R10 read no effect");
    tick_sec = 1'b1; second = 8'h01; step(1'b0, "R10 tick_sec no effect");
    second = 8'h29; step(1'b0, "R10 second 29");
    second = 8'h30; step(1'b1, "R10 second 30 release");
    second = 8'h31; step(1'b1, "R10 stays released");
    second = 8'h00; tick_min = 1'b1; step(1'b0, "R10 next minute");
    cfg = 8'h00; step(1'b1, "R11 leave mode");
    cfg = 8'h0A; step(1'b1, "R11 pending dropped");

    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule